// File: doc/BRIEF.md
# EEPROM Page Programmer

This block is the host-side engine that programs a parallel 8K x 8 EEPROM. It drives the chip-enable, output-enable and write-enable strobes plus the address and data buses. Software first loads the bytes for one page into a small internal FIFO. It then pulses `start_i` with a start address and a byte count. The controller loads those bytes into the device one strobe at a time, at a steady pace, and keeps every gap between strobes inside the window the device allows for a page load.

After the last byte the controller reads back the last written address until the device reports that its internal write cycle has finished. Completion is recognised in two ways: the top data bit returns the true value of the last byte, or bit 6 reads the same on two reads in a row. Every waveform time is a parameter counted in clock cycles, and the defaults suit a 50 MHz clock. If polling runs longer than the timeout (10 ms by default), the controller flags an error.

Top module: `eeprom_page_prog`

## Requirements
- R1: In idle, `start_i` accepts a request if the count is 1 to 64, the bytes stay inside one 64-byte page (address bits [5:0] plus count at most 64), and the FIFO holds at least that many bytes. The bytes are then written in FIFO order to consecutive addresses from the start address, with exactly one write-enable strobe per byte.
- R2: Any other request is rejected. `error_o` rises, `busy_o` stays low, no strobe is issued, and the FIFO contents are kept for the next request.
- R3: Every write-enable low pulse lasts exactly `PULSE_CYC` cycles (160 ns by default).
- R4: Address and data settle `SETUP_CYC` cycles before write-enable falls, do not change while it is low, and are still held in the cycle after it rises.
- R5: Between consecutive strobes of one page, write-enable stays high for exactly `GAP_CYC` cycles. The default is 240 ns, which lies inside the 0.2 to 2 µs load window.
- R6: Output-enable stays high while write data is driven, and for at least one cycle before the first strobe and after the last. Chip-enable is low whenever write-enable is low. The data bus is never driven while output-enable is low.
- R7: Each poll read holds output-enable low at the last written address for `READ_CYC` cycles. Reads are separated by `POLL_GAP_CYC` cycles with output-enable high. A read whose bit 7 equals bit 7 of the last written byte ends the request with `done_o`.
- R8: Two consecutive poll reads with the same bit 6 also end the request with `done_o`, even if bit 7 never matches.
- R9: If polling has not completed within `TIMEOUT_CYC` cycles of its start, the controller raises `error_o` and returns to idle.
- R10: After reset all strobes are high, the data bus is undriven and all flags are low. `busy_o` is high from acceptance until the request ends. `done_o` and `error_o` keep their values until the next `start_i`, and they are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Write `push_data_i` into the FIFO (ignored when the FIFO is full) |
| push_data_i | input | 8 | Byte to queue |
| start_i | input | 1 | Request strobe, sampled in idle |
| start_addr_i | input | 13 | First device address of the burst |
| start_len_i | input | 7 | Number of bytes in the burst |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Last request completed |
| error_o | output | 1 | Last request rejected or timed out |
| ee_addr_o | output | 13 | Device address bus |
| ee_dq_o | output | 8 | Write data toward the device |
| ee_dq_oe_o | output | 1 | Drive enable for the data bus |
| ee_dq_i | input | 8 | Data read from the device |
| ee_ce_no | output | 1 | Chip enable, active low |
| ee_oe_no | output | 1 | Output enable, active low |
| ee_we_no | output | 1 | Write enable, active low |

## Verification
A behavioural device model in the bench times every strobe, edge against edge, and keeps the loaded page. A controller that clipped the pulse, moved the address inside the strobe, or stretched a gap past 2 µs would increment one of the model's violation counters. Page-boundary requests are a key corner case: a request ending on the last byte of a page must pass, while one that spills a single byte past it, a zero count, or a count larger than the FIFO holds must be refused. A design that popped bytes on refusal would then write the wrong data in the next accepted burst. A model that leaves bit 7 wrong after finishing tests the bit-6 path alone, so a controller that watched only bit 7 would time out. A model that never finishes checks that the error appears no earlier than the timeout and not much later.

// File: rtl/eeprom_prog_pkg.sv
`timescale 1ns/1ps
package eeprom_prog_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_PGAP,
    ST_PREAD
  } prog_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eeprom_prog_fifo.sv
`timescale 1ns/1ps
module eeprom_prog_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic [DATA_W-1:0]            push_data_i,
  input  logic                         pop_i,
  output logic [DATA_W-1:0]            head_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_push, do_pop;

  assign do_push = push_i && (cnt_q != CNT_W'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push)
        wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + PTR_W'(1);
      if (do_pop)
        rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + PTR_W'(1);
      if (do_push && !do_pop)      cnt_q <= cnt_q + CNT_W'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/eeprom_req_check.sv
`timescale 1ns/1ps
module eeprom_req_check #(
  parameter int PAGE_BYTES = 64,
  parameter int PAGE_W     = 6,
  parameter int LEN_W      = 7,
  parameter int FCNT_W     = 7
) (
  input  logic [PAGE_W-1:0] offset_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [FCNT_W-1:0] fifo_cnt_i,
  output logic              ok_o
);
  logic nonzero, fits_page, enough_data;

  assign nonzero     = (len_i != '0);
  // the end offset may equal the page size but not pass it
  assign fits_page   = (32'(offset_i) + 32'(len_i)) <= 32'(PAGE_BYTES);
  assign enough_data = 32'(fifo_cnt_i) >= 32'(len_i);
  assign ok_o        = nonzero && fits_page && enough_data;
endmodule

// File: rtl/eeprom_poll_eval.sv
`timescale 1ns/1ps
module eeprom_poll_eval (
  input  logic rd_b7_i,
  input  logic rd_b6_i,
  input  logic exp_b7_i,
  input  logic prev_b6_i,
  input  logic have_prev_i,
  output logic finished_o
);
  logic data_match, toggle_idle;

  assign data_match  = (rd_b7_i == exp_b7_i);
  assign toggle_idle = have_prev_i && (rd_b6_i == prev_b6_i);
  assign finished_o  = data_match || toggle_idle;
endmodule

// File: rtl/eeprom_page_prog.sv
`timescale 1ns/1ps
module eeprom_page_prog
  import eeprom_prog_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int DATA_W       = 8,
  parameter int PAGE_BYTES   = 64,
  parameter int FIFO_DEPTH   = 64,
  parameter int SETUP_CYC    = 2,
  parameter int PULSE_CYC    = 8,
  parameter int GAP_CYC      = 12,
  parameter int READ_CYC     = 12,
  parameter int POLL_GAP_CYC = 3,
  parameter int TIMEOUT_CYC  = 500000
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 push_i,
  input  logic [DATA_W-1:0]                    push_data_i,
  input  logic                                 start_i,
  input  logic [ADDR_W-1:0]                    start_addr_i,
  input  logic [$clog2(PAGE_BYTES+1)-1:0]      start_len_i,
  output logic                                 busy_o,
  output logic                                 done_o,
  output logic                                 error_o,
  output logic [ADDR_W-1:0]                    ee_addr_o,
  output logic [DATA_W-1:0]                    ee_dq_o,
  output logic                                 ee_dq_oe_o,
  input  logic [DATA_W-1:0]                    ee_dq_i,
  output logic                                 ee_ce_no,
  output logic                                 ee_oe_no,
  output logic                                 ee_we_no
);
  localparam int PAGE_W   = $clog2(PAGE_BYTES);
  localparam int LEN_W    = $clog2(PAGE_BYTES + 1);
  localparam int FCNT_W   = $clog2(FIFO_DEPTH + 1);
  localparam int HOLD_CYC = GAP_CYC - SETUP_CYC;
  localparam int PH_MAX   = max2(max2(max2(SETUP_CYC, PULSE_CYC), max2(HOLD_CYC, READ_CYC)),
                                 POLL_GAP_CYC);
  localparam int PH_W     = $clog2(PH_MAX + 1);
  localparam int TMO_W    = $clog2(TIMEOUT_CYC + 1);

  localparam logic [PH_W-1:0] SETUP_LD = PH_W'(SETUP_CYC - 1);
  localparam logic [PH_W-1:0] PULSE_LD = PH_W'(PULSE_CYC - 1);
  localparam logic [PH_W-1:0] HOLD_LD  = PH_W'(HOLD_CYC - 1);
  localparam logic [PH_W-1:0] READ_LD  = PH_W'(READ_CYC - 1);
  localparam logic [PH_W-1:0] PGAP_LD  = PH_W'(POLL_GAP_CYC - 1);

  prog_state_e        state_q, state_d;
  logic [PH_W-1:0]    cnt_q, cnt_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [DATA_W-1:0]  wdata_q, wdata_d;
  logic [LEN_W-1:0]   left_q, left_d;
  logic [TMO_W-1:0]   tmo_q, tmo_d;
  logic               prev6_q, prev6_d;
  logic               have_prev_q, have_prev_d;
  logic               done_q, done_d;
  logic               err_q, err_d;
  logic               ce_nq, oe_nq, we_nq, dq_oe_q;

  logic               pop;
  logic [DATA_W-1:0]  fifo_head;
  logic [FCNT_W-1:0]  fifo_cnt;
  logic               req_ok;
  logic               poll_done;
  logic               phase_end;
  logic               tmo_hit;

  eeprom_prog_fifo #(
    .DATA_W (DATA_W),
    .DEPTH  (FIFO_DEPTH)
  ) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_i),
    .push_data_i (push_data_i),
    .pop_i       (pop),
    .head_o      (fifo_head),
    .count_o     (fifo_cnt)
  );

  eeprom_req_check #(
    .PAGE_BYTES (PAGE_BYTES),
    .PAGE_W     (PAGE_W),
    .LEN_W      (LEN_W),
    .FCNT_W     (FCNT_W)
  ) u_req_check (
    .offset_i   (start_addr_i[PAGE_W-1:0]),
    .len_i      (start_len_i),
    .fifo_cnt_i (fifo_cnt),
    .ok_o       (req_ok)
  );

  eeprom_poll_eval u_poll_eval (
    .rd_b7_i     (ee_dq_i[DATA_W-1]),
    .rd_b6_i     (ee_dq_i[DATA_W-2]),
    .exp_b7_i    (wdata_q[DATA_W-1]),
    .prev_b6_i   (prev6_q),
    .have_prev_i (have_prev_q),
    .finished_o  (poll_done)
  );

  assign phase_end = (cnt_q == '0);
  assign tmo_hit   = (tmo_q == TMO_W'(TIMEOUT_CYC - 1));

  always_comb begin
    state_d     = state_q;
    cnt_d       = phase_end ? cnt_q : cnt_q - PH_W'(1);
    addr_d      = addr_q;
    wdata_d     = wdata_q;
    left_d      = left_q;
    tmo_d       = tmo_q;
    prev6_d     = prev6_q;
    have_prev_d = have_prev_q;
    done_d      = done_q;
    err_d       = err_q;
    pop         = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          done_d = 1'b0;
          if (req_ok) begin
            state_d = ST_SETUP;
            cnt_d   = SETUP_LD;
            addr_d  = start_addr_i;
            wdata_d = fifo_head;
            left_d  = start_len_i;
            pop     = 1'b1;
            err_d   = 1'b0;
          end else begin
            err_d   = 1'b1;
          end
        end
      end
      ST_SETUP: begin
        if (phase_end) begin
          state_d = ST_PULSE;
          cnt_d   = PULSE_LD;
        end
      end
      ST_PULSE: begin
        if (phase_end) begin
          state_d = ST_HOLD;
          cnt_d   = HOLD_LD;
        end
      end
      ST_HOLD: begin
        if (phase_end) begin
          if (left_q > LEN_W'(1)) begin
            state_d = ST_SETUP;
            cnt_d   = SETUP_LD;
            addr_d  = addr_q + ADDR_W'(1);
            wdata_d = fifo_head;
            left_d  = left_q - LEN_W'(1);
            pop     = 1'b1;
          end else begin
            // address and last byte stay put for polling
            state_d     = ST_PGAP;
            cnt_d       = PGAP_LD;
            tmo_d       = '0;
            have_prev_d = 1'b0;
          end
        end
      end
      ST_PGAP: begin
        tmo_d = tmo_q + TMO_W'(1);
        if (tmo_hit) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end else if (phase_end) begin
          state_d = ST_PREAD;
          cnt_d   = READ_LD;
        end
      end
      ST_PREAD: begin
        tmo_d = tmo_q + TMO_W'(1);
        if (phase_end && poll_done) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else if (tmo_hit) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end else if (phase_end) begin
          state_d     = ST_PGAP;
          cnt_d       = PGAP_LD;
          prev6_d     = ee_dq_i[DATA_W-2];
          have_prev_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      addr_q      <= '0;
      wdata_q     <= '0;
      left_q      <= '0;
      tmo_q       <= '0;
      prev6_q     <= 1'b0;
      have_prev_q <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      ce_nq       <= 1'b1;
      oe_nq       <= 1'b1;
      we_nq       <= 1'b1;
      dq_oe_q     <= 1'b0;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      addr_q      <= addr_d;
      wdata_q     <= wdata_d;
      left_q      <= left_d;
      tmo_q       <= tmo_d;
      prev6_q     <= prev6_d;
      have_prev_q <= have_prev_d;
      done_q      <= done_d;
      err_q       <= err_d;
      // strobes come from flops decoded on the next state: glitch free and aligned with addr/data
      ce_nq       <= (state_d == ST_IDLE);
      oe_nq       <= (state_d != ST_PREAD);
      we_nq       <= (state_d != ST_PULSE);
      dq_oe_q     <= (state_d == ST_SETUP) || (state_d == ST_PULSE) || (state_d == ST_HOLD);
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign error_o    = err_q;
  assign ee_addr_o  = addr_q;
  assign ee_dq_o    = wdata_q;
  assign ee_dq_oe_o = dq_oe_q;
  assign ee_ce_no   = ce_nq;
  assign ee_oe_no   = oe_nq;
  assign ee_we_no   = we_nq;
endmodule

// File: rtl/eeprom_page_prog_chk.sv
`timescale 1ns/1ps
module eeprom_page_prog_chk #(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 8,
  parameter int GAP_CYC   = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              error_o,
  input logic [ADDR_W-1:0] ee_addr_o,
  input logic [DATA_W-1:0] ee_dq_o,
  input logic              ee_dq_oe_o,
  input logic              ee_ce_no,
  input logic              ee_oe_no,
  input logic              ee_we_no
);
  logic [15:0] low_cnt_q, hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= '0;
      hi_cnt_q  <= '0;
    end else begin
      low_cnt_q <= !ee_we_no ? low_cnt_q + 16'd1 : '0;
      hi_cnt_q  <= (ee_we_no && ee_dq_oe_o) ? hi_cnt_q + 16'd1 : '0;
    end
  end

  a_r3_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ee_we_no && low_cnt_q != 16'd0) |-> low_cnt_q == 16'(PULSE_CYC));

  a_r5_strobe_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ee_we_no && hi_cnt_q != 16'd0) |->
      (hi_cnt_q == 16'(SETUP_CYC) || hi_cnt_q == 16'(GAP_CYC)));

  a_r4_stable_in_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ee_we_no && $past(!ee_we_no)) |-> ($stable(ee_addr_o) && $stable(ee_dq_o)));

  a_r4_hold_after_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ee_we_no) |-> ($stable(ee_addr_o) && $stable(ee_dq_o) && ee_dq_oe_o));

  a_r6_read_not_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ee_oe_no |-> (ee_we_no && !ee_dq_oe_o));

  a_r6_write_in_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ee_we_no |-> (!ee_ce_no && ee_oe_no && ee_dq_oe_o));

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ee_ce_no && ee_we_no && ee_oe_no && !ee_dq_oe_o));

  a_r10_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && error_o));
endmodule

bind eeprom_page_prog eeprom_page_prog_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .SETUP_CYC (SETUP_CYC),
  .PULSE_CYC (PULSE_CYC),
  .GAP_CYC   (GAP_CYC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .error_o    (error_o),
  .ee_addr_o  (ee_addr_o),
  .ee_dq_o    (ee_dq_o),
  .ee_dq_oe_o (ee_dq_oe_o),
  .ee_ce_no   (ee_ce_no),
  .ee_oe_no   (ee_oe_no),
  .ee_we_no   (ee_we_no)
);

// File: tb/eeprom_page_prog_tb_top.sv
`timescale 1ns/1ps
module eeprom_page_prog_tb_top;
  localparam int TMO      = 2000;
  localparam int SETUP    = 2;
  localparam int PULSE    = 8;
  localparam int GAP      = 12;
  localparam int OUT_DONE = 0;
  localparam int OUT_REJ  = 1;
  localparam int OUT_TMO  = 2;

  typedef struct packed {
    logic [12:0] addr;
    logic [6:0]  len;
    logic [16:0] prog;
    logic        dq7bad;
    logic [1:0]  outc;
  } vec_t;

  // addr, len, device program cycles, bit7 stays wrong after finish, outcome
  localparam vec_t VEC [8] = '{
    '{13'h0000, 7'd1,  17'd200,   1'b0, 2'd0},
    '{13'h0040, 7'd64, 17'd300,   1'b0, 2'd0},
    '{13'h013F, 7'd1,  17'd100,   1'b0, 2'd0},
    '{13'h0105, 7'd0,  17'd100,   1'b0, 2'd1},
    '{13'h0038, 7'd9,  17'd100,   1'b0, 2'd1},
    '{13'h1FC4, 7'd16, 17'd250,   1'b1, 2'd0},
    '{13'h0800, 7'd5,  17'd60000, 1'b0, 2'd2},
    '{13'h0A20, 7'd32, 17'd1,     1'b0, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push = 1'b0;
  logic [7:0]  push_data = '0;
  logic        start = 1'b0;
  logic [12:0] start_addr = '0;
  logic [6:0]  start_len = '0;
  logic        busy, done, error;
  logic [12:0] ee_addr;
  logic [7:0]  ee_dq_o, ee_dq_i;
  logic        ee_dq_oe, ee_ce_n, ee_oe_n, ee_we_n;

  always #10 clk = ~clk;

  eeprom_page_prog #(.TIMEOUT_CYC(TMO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .push_data_i(push_data),
    .start_i(start), .start_addr_i(start_addr), .start_len_i(start_len),
    .busy_o(busy), .done_o(done), .error_o(error),
    .ee_addr_o(ee_addr), .ee_dq_o(ee_dq_o), .ee_dq_oe_o(ee_dq_oe), .ee_dq_i(ee_dq_i),
    .ee_ce_no(ee_ce_n), .ee_oe_no(ee_oe_n), .ee_we_no(ee_we_n)
  );

  // ---------------- device model ----------------
  logic [7:0]  pg [64];
  logic [6:0]  pg_tag = '0;
  logic [12:0] last_wa = '0;
  logic [7:0]  last_wd = '0;
  logic        tog = 1'b0;
  logic        dq7bad_m = 1'b0;
  int          prog_m = 0;
  int          busy_rem = 0;
  int          cyc = 0;
  int          a_chg = 0, d_chg = 0, oe_low = -10, fall = 0, rise = 0;
  int          strobes = 0;
  int          v_pw = 0, v_su = 0, v_gap = 0, v_oe = 0, v_rd = 0, v_pg = 0;
  logic        in_burst = 1'b0;
  logic [12:0] a_prev = '0;
  logic [7:0]  d_prev = '0;
  logic        we_prev = 1'b1, oe_prev = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (busy_rem > 0) busy_rem--;
    if (ee_addr !== a_prev) a_chg = cyc;
    if (ee_dq_o !== d_prev) d_chg = cyc;
    if (!ee_oe_n && oe_prev) begin
      tog = ~tog;
      if (ee_addr !== last_wa) v_rd++;
    end
    if (!ee_oe_n && ee_dq_oe) v_oe++;
    if (!ee_we_n && we_prev) begin
      if (ee_ce_n) v_oe++;
      if (cyc - oe_low < 2) v_oe++;
      if (!ee_dq_oe) v_su++;
      if (in_burst && (cyc - rise < 10 || cyc - rise > 100)) v_gap++;
      fall = cyc;
    end
    if (!ee_oe_n) oe_low = cyc;
    if (!ee_we_n && !ee_oe_n) v_oe++;
    if (!ee_we_n && (a_chg == cyc || d_chg == cyc)) v_su++;
    if (ee_we_n && !we_prev) begin
      if (cyc - fall < 8) v_pw++;
      if (cyc - d_chg < 3) v_su++;
      if (a_chg == cyc || d_chg == cyc) v_su++;
      if (in_burst && ee_addr[12:6] != pg_tag) v_pg++;
      if (!in_burst) pg_tag = ee_addr[12:6];
      pg[ee_addr[5:0]] = ee_dq_o;
      in_burst = 1'b1;
      strobes++;
      last_wa = ee_addr;
      last_wd = ee_dq_o;
      busy_rem = prog_m;
      rise = cyc;
    end
    if (ee_ce_n || !ee_oe_n) in_burst = 1'b0;
    a_prev  = ee_addr;
    d_prev  = ee_dq_o;
    we_prev = ee_we_n;
    oe_prev = ee_oe_n;
  end

  always_comb begin
    if (!ee_ce_n && !ee_oe_n) begin
      if (busy_rem > 0)  ee_dq_i = {~last_wd[7], tog, last_wd[5:0]};
      else if (dq7bad_m) ee_dq_i = {~pg[ee_addr[5:0]][7], pg[ee_addr[5:0]][6:0]};
      else               ee_dq_i = pg[ee_addr[5:0]];
    end else begin
      ee_dq_i = 8'h00;
    end
  end

  // ---------------- checking ----------------
  int         n_chk = 0, n_err = 0;
  int         seed = 0;
  logic [7:0] q [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push_byte(input logic [7:0] b);
    push = 1'b1;
    push_data = b;
    @(negedge clk);
    push = 1'b0;
    q.push_back(b);
  endtask

  task automatic issue(input logic [12:0] a, input logic [6:0] l, output int busy_seen);
    start_addr = a;
    start_len  = l;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy_seen = int'(busy);
  endtask

  task automatic wait_idle(output int dur);
    int n = 0;
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
    dur = n;
    if (n >= 20000) chk(1'b0, "WD", "request never ended", n, 20000);
    @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v);
    int s0, bs, dur, need, good, hi;
    logic [7:0] e;
    need = int'(v.len) - q.size();
    for (int i = 0; i < need; i++) begin
      push_byte(8'(seed * 37 + 5));
      seed++;
    end
    s0 = strobes;
    dq7bad_m = v.dq7bad;
    prog_m = int'(v.prog);
    issue(v.addr, v.len, bs);
    wait_idle(dur);
    if (v.outc == 2'(OUT_REJ)) begin
      chk(error == 1'b1 && done == 1'b0, "R2", "reject flags err", int'(error), 1);
      chk(bs == 0, "R2", "busy on reject", bs, 0);
      chk(strobes == s0, "R2", "strobes on reject", strobes - s0, 0);
    end else begin
      chk(bs == 1, "R10", "busy after accept", bs, 1);
      chk(strobes - s0 == int'(v.len), "R1", "strobe count", strobes - s0, int'(v.len));
      good = 0;
      for (int i = 0; i < int'(v.len); i++) begin
        e = q.pop_front();
        if (pg[6'(int'(v.addr[5:0]) + i)] == e) good++;
      end
      chk(good == int'(v.len), "R1", "bytes stored in order", good, int'(v.len));
      chk(pg_tag == v.addr[12:6], "R1", "page written", int'(pg_tag), int'(v.addr[12:6]));
      if (v.outc == 2'(OUT_DONE)) begin
        chk(done == 1'b1 && error == 1'b0, v.dq7bad ? "R8" : "R7", "completion",
            int'(done), 1);
        repeat (5) @(negedge clk);
        chk(done == 1'b1 && !busy, "R10", "done held", int'(done), 1);
      end else begin
        hi = TMO + int'(v.len) * (SETUP + PULSE + GAP) + 40;
        chk(error == 1'b1 && done == 1'b0, "R9", "timeout error", int'(error), 1);
        chk(dur >= TMO, "R9", "not before timeout", dur, TMO);
        chk(dur <= hi, "R9", "not long after timeout", dur, hi);
      end
    end
  endtask

  initial begin
    int bs, dur;
    for (int i = 0; i < 64; i++) pg[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !error, "R10", "flags in reset", int'({busy, done, error}), 0);
    chk(ee_ce_n && ee_oe_n && ee_we_n && !ee_dq_oe, "R10", "strobes in reset",
        int'({ee_ce_n, ee_oe_n, ee_we_n, ee_dq_oe}), 14);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 8; v++) run_vec(VEC[v]);

    // R2: FIFO short of the count, bytes must survive for the next request
    prog_m = 50;
    dq7bad_m = 1'b0;
    for (int i = 0; i < 3; i++) begin
      push_byte(8'(seed * 37 + 5));
      seed++;
    end
    issue(13'h0200, 7'd5, bs);
    wait_idle(dur);
    chk(error == 1'b1 && bs == 0, "R2", "short FIFO rejected", int'(error), 1);
    run_vec('{13'h0300, 7'd3, 17'd50, 1'b0, 2'd0});

    // R2: count above a page
    for (int i = 0; i < 64; i++) begin
      push_byte(8'(seed * 37 + 5));
      seed++;
    end
    issue(13'h0000, 7'd65, bs);
    wait_idle(dur);
    chk(error == 1'b1 && bs == 0, "R2", "count above page rejected", int'(error), 1);
    run_vec('{13'h0480, 7'd64, 17'd120, 1'b0, 2'd0});

    chk(v_pw == 0,  "R3", "short write pulses", v_pw, 0);
    chk(v_su == 0,  "R4", "setup/hold faults", v_su, 0);
    chk(v_gap == 0, "R5", "gap outside window", v_gap, 0);
    chk(v_pg == 0,  "R1", "burst crossed page", v_pg, 0);
    chk(v_oe == 0,  "R6", "strobe overlap faults", v_oe, 0);
    chk(v_rd == 0,  "R7", "poll at wrong address", v_rd, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_err++;
    $display("FAIL WD watchdog expired: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule